// File: doc/BRIEF.md
# Fixed-Point Aligned Adder/Subtractor

This unit adds or subtracts two signed fixed-point operands. Each operand, and the result, has its own format. A format is given as a total bit count N, which includes the sign, and an integer count G, which excludes the sign. The count of fractional bits is then F = N - 1 - G. Both operands are first brought to the result's binary-point position. A bit below the result's LSB is simply dropped, which rounds that operand toward minus infinity. A missing fraction bit is filled with zero. Only after this alignment is the sum or difference formed.

The carry chain starts at the result LSB. For subtraction, the second operand is inverted and a carry of one enters at that LSB. So a dropped bit can never carry or borrow into the result. The result keeps the low bits of the exact aligned sum. There is no saturation and no flag.

A single control bit picks add or subtract, and a parameter sets that bit's polarity. A second parameter chooses one of two output modes: a purely combinational output, or one register stage.

Top module: `fxa_addsub`

## Requirements
- R1: An operand or result of N bits with integer count G has F = N - 1 - G fractional bits, and its value is the two's-complement integer of its bits times 2^-F. G may be zero or negative, but not above N - 1.
- R2: An operand with more fractional bits than the result is truncated toward minus infinity to the result LSB before the operation. Its discarded bits never carry or borrow into the result.
- R3: When add is selected, the result is the aligned first operand plus the aligned second operand.
- R4: When subtract is selected, the result is the aligned first operand minus the aligned second operand. This is formed by inverting the second operand and injecting a carry of one at the result LSB.
- R5: With ADD_POL = 1, op_ctl = 1 selects add and op_ctl = 0 selects subtract. With ADD_POL = 0, the meanings swap.
- R6: The result is the low Y_W bits, in two's complement, of the exact aligned sum or difference. It wraps with no saturation.
- R7: With REG_OUT = 0, y_out follows a_in, b_in and op_ctl within the same cycle, with no clock edge in between.
- R8: With REG_OUT = 1, y_out shows the result for the inputs sampled at the previous rising edge of clk. rst is synchronous and active high, and an edge with rst high loads zero.
- R9: An operand with fewer fractional bits than the result is extended exactly, by appending zero fraction bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| a_in | input | A_W | First operand, format (A_W, A_G) |
| b_in | input | B_W | Second operand, format (B_W, B_G) |
| op_ctl | input | 1 | Add/subtract select; its polarity is set by ADD_POL |
| y_out | output | Y_W | Result, format (Y_W, Y_G) |

## Verification
Truncation of the second operand and the subtract carry-in both act at the result LSB, so both can matter in a single operation. This happens whenever a subtraction's second operand has set bits below the result LSB. Directed vectors subtract such operands; one is an operand whose only set bits are discarded, and in that case no borrow may appear. Random vectors then mix both operations. Every output is compared with a model that floors each operand on its own by integer division and only then adds or subtracts, so an extra borrow or carry shows up as a miscompare. In the registered variant, reset is also asserted in the middle of a run, and the edge after it must yield zero whatever operands were applied.

// File: rtl/fxa_pkg.sv
package fxa_pkg;

    typedef enum logic {
        OP_ADD = 1'b0,
        OP_SUB = 1'b1
    } fxa_op_e;

    // fractional bit count of a signed format (total bits, integer bits without sign)
    function automatic int frac_bits(input int total_w, input int int_g);
        return total_w - 1 - int_g;
    endfunction

    function automatic int imax(input int x, input int y);
        return (x > y) ? x : y;
    endfunction

    function automatic int clip0(input int x);
        return (x > 0) ? x : 0;
    endfunction

endpackage

// File: rtl/fxa_align.sv
module fxa_align #(
    parameter int IN_W  = 8,
    parameter int IN_F  = 4,
    parameter int OUT_F = 4,
    parameter int OUT_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IN_W-1:0]  din,
    output logic [OUT_W-1:0] dout
);
    localparam int SHR = fxa_pkg::clip0(IN_F - OUT_F);
    localparam int SHL = fxa_pkg::clip0(OUT_F - IN_F);
    localparam int EW  = fxa_pkg::imax(IN_W + SHL, OUT_W);

    logic signed [IN_W-1:0] x_s;
    logic signed [EW-1:0]   ext;
    logic signed [EW-1:0]   scaled;
    logic signed [EW-1:0]   moved;
    logic signed [EW-1:0]   back;
    logic signed [EW-1:0]   resid;

    assign x_s    = $signed(din);
    assign ext    = EW'(x_s);
    assign scaled = ext <<< SHL;
    // arithmetic right shift drops low bits toward minus infinity
    assign moved  = scaled >>> SHR;
    assign dout   = moved[OUT_W-1:0];

    assign back   = EW'($signed(dout)) <<< SHR;
    assign resid  = scaled - back;

    AST_FLOOR_ALIGN: assert property (@(posedge clk) disable iff (rst)
        (resid >>> SHR) == '0);  // R2
    AST_ALIGN_FIT: assert property (@(posedge clk) disable iff (rst)
        moved == EW'($signed(dout)));  // R1

endmodule

// File: rtl/fxa_opsel.sv
module fxa_opsel #(
    parameter bit ADD_POL = 1'b1
) (
    input  logic            op_ctl,
    output fxa_pkg::fxa_op_e op
);
    generate
        if (ADD_POL) begin : g_pos
            assign op = op_ctl ? fxa_pkg::OP_ADD : fxa_pkg::OP_SUB;
        end else begin : g_neg
            assign op = op_ctl ? fxa_pkg::OP_SUB : fxa_pkg::OP_ADD;
        end
    endgenerate
endmodule

// File: rtl/fxa_ripple.sv
module fxa_ripple #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] sum
);
    logic [W-1:0] b_eff;
    logic [W-1:0] cin;

    assign b_eff  = b ^ {W{sub}};
    assign cin[0] = sub;  // carry enters at the result LSB

    generate
        for (genvar i = 0; i < W; i++) begin : g_bit
            assign sum[i] = a[i] ^ b_eff[i] ^ cin[i];
            if (i < W - 1) begin : g_carry
                assign cin[i+1] = (a[i] & b_eff[i]) | (cin[i] & (a[i] ^ b_eff[i]));
            end
        end
    endgenerate

    AST_ADD_IDENTITY: assert property (@(posedge clk) disable iff (rst)
        (!sub && b == '0) |-> sum == a);  // R3
    AST_NEG_B: assert property (@(posedge clk) disable iff (rst)
        (sub && a == '0) |-> W'(sum + b) == '0);  // R4

endmodule

// File: rtl/fxa_addsub.sv
module fxa_addsub #(
    parameter int A_W     = 8,
    parameter int A_G     = 3,
    parameter int B_W     = 10,
    parameter int B_G     = 1,
    parameter int Y_W     = 8,
    parameter int Y_G     = 3,
    parameter bit ADD_POL = 1'b1,
    parameter bit REG_OUT = 1'b0
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [A_W-1:0] a_in,
    input  logic [B_W-1:0] b_in,
    input  logic           op_ctl,
    output logic [Y_W-1:0] y_out
);
    localparam int A_F   = fxa_pkg::frac_bits(A_W, A_G);
    localparam int B_F   = fxa_pkg::frac_bits(B_W, B_G);
    localparam int Y_F   = fxa_pkg::frac_bits(Y_W, Y_G);
    // sign + guard bit above the widest integer part, output precision below
    localparam int INT_W = fxa_pkg::imax(fxa_pkg::imax(A_G, B_G), Y_G) + 2 + Y_F;

    logic [INT_W-1:0] a_al;
    logic [INT_W-1:0] b_al;
    logic [INT_W-1:0] sum_full;
    logic [Y_W-1:0]   y_comb;
    fxa_pkg::fxa_op_e op;
    logic             sub_sel;

    fxa_align #(.IN_W(A_W), .IN_F(A_F), .OUT_F(Y_F), .OUT_W(INT_W)) u_al_a (
        .clk(clk), .rst(rst), .din(a_in), .dout(a_al)
    );
    fxa_align #(.IN_W(B_W), .IN_F(B_F), .OUT_F(Y_F), .OUT_W(INT_W)) u_al_b (
        .clk(clk), .rst(rst), .din(b_in), .dout(b_al)
    );

    fxa_opsel #(.ADD_POL(ADD_POL)) u_opsel (
        .op_ctl(op_ctl), .op(op)
    );
    assign sub_sel = (op == fxa_pkg::OP_SUB);

    fxa_ripple #(.W(INT_W)) u_core (
        .clk(clk), .rst(rst), .a(a_al), .b(b_al), .sub(sub_sel), .sum(sum_full)
    );

    // wraparound: keep only the output format's bit positions
    assign y_comb = sum_full[Y_W-1:0];

    AST_SUB_SELF: assert property (@(posedge clk) disable iff (rst)
        (sub_sel && a_al == b_al) |-> sum_full == '0);  // R4

    generate
        if (REG_OUT) begin : g_reg
            logic [Y_W-1:0] y_q;
            always_ff @(posedge clk) begin
                if (rst) y_q <= '0;
                else     y_q <= y_comb;
            end
            assign y_out = y_q;

            AST_RST_CLEAR: assert property (@(posedge clk) disable iff (rst)
                $fell(rst) |-> y_out == '0);  // R8
        end else begin : g_comb
            assign y_out = y_comb;
        end
    endgenerate

endmodule

// File: tb/fxa_addsub_tb.sv
module fxa_addsub_tb_top;
    localparam int CLK_PERIOD = 10;

    // variant I: combinational, ADD_POL = 1
    localparam int IA_W = 8,  IA_F = 4;
    localparam int IB_W = 10, IB_F = 8;
    localparam int IY_W = 8,  IY_F = 4;
    // variant R: registered, ADD_POL = 0, zero/negative integer counts
    localparam int RA_W = 4,  RA_F = 6;   // (4,-3)
    localparam int RB_W = 6,  RB_F = 5;   // (6, 0)
    localparam int RY_W = 6,  RY_F = 6;   // (6,-1)

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [IA_W-1:0] a_i = '0;
    logic [IB_W-1:0] b_i = '0;
    logic            op_i = 1'b1;
    logic [IY_W-1:0] y_i;
    logic [RA_W-1:0] a_r = '0;
    logic [RB_W-1:0] b_r = '0;
    logic            op_r = 1'b0;
    logic [RY_W-1:0] y_r;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;
    longint exp_q[$];
    string  tag_q[$];
    logic [31:0] seed = 32'h1234_5678;

    always #(CLK_PERIOD/2) clk = ~clk;

    fxa_addsub dut_i (
        .clk(clk), .rst(rst), .a_in(a_i), .b_in(b_i), .op_ctl(op_i), .y_out(y_i)
    );

    fxa_addsub #(
        .A_W(4), .A_G(-3), .B_W(6), .B_G(0), .Y_W(6), .Y_G(-1),
        .ADD_POL(1'b0), .REG_OUT(1'b1)
    ) dut_reg_i (
        .clk(clk), .rst(rst), .a_in(a_r), .b_in(b_r), .op_ctl(op_r), .y_out(y_r)
    );

    function automatic longint sx(input longint raw, input int w);
        longint m;
        m = raw & ((longint'(1) << w) - 1);
        if (m >= (longint'(1) << (w - 1))) return m - (longint'(1) << w);
        return m;
    endfunction

    function automatic longint floor_div(input longint v, input longint d);
        longint q;
        q = v / d;
        if ((v % d) != 0 && v < 0) q = q - 1;
        return q;
    endfunction

    function automatic longint to_lsb(input longint v, input int f, input int yf);
        if (f >= yf) return floor_div(v, longint'(1) << (f - yf));
        return v * (longint'(1) << (yf - f));
    endfunction

    function automatic longint model(input longint a, input int aw, input int af,
                                     input longint b, input int bw, input int bf,
                                     input int yw, input int yf, input bit sub);
        longint r;
        r = to_lsb(sx(a, aw), af, yf);
        if (sub) r = r - to_lsb(sx(b, bw), bf, yf);
        else     r = r + to_lsb(sx(b, bw), bf, yf);
        return r & ((longint'(1) << yw) - 1);
    endfunction

    task automatic chk(input string tag, input longint act, input longint exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(input logic r,
                        input logic [IA_W-1:0] ai, input logic [IB_W-1:0] bi, input logic oi,
                        input string ti,
                        input logic [RA_W-1:0] ar, input logic [RB_W-1:0] br, input logic orr,
                        input string tr);
        longint e;
        @(negedge clk);
        if (exp_q.size() > 0) chk(tag_q.pop_front(), longint'(y_r), exp_q.pop_front());
        rst  = r;
        a_i  = ai; b_i = bi; op_i = oi;
        a_r  = ar; b_r = br; op_r = orr;
        #1;
        // variant I: add when op_ctl = 1
        e = model(ai, IA_W, IA_F, bi, IB_W, IB_F, IY_W, IY_F, !oi);
        chk(ti, longint'(y_i), e);
        // variant R: add when op_ctl = 0
        if (r) e = 0;
        else   e = model(ar, RA_W, RA_F, br, RB_W, RB_F, RY_W, RY_F, orr);
        exp_q.push_back(e);
        tag_q.push_back(tr);
    endtask

    function automatic logic [31:0] lcg(input logic [31:0] s);
        return s * 32'd1664525 + 32'd1013904223;
    endfunction

    initial begin
        // reset phase: registered variant must read zero (R8)
        step(1'b1, 8'h00, 10'h000, 1'b1, "R3 reset-add", 4'h0, 6'h00, 1'b0, "R8 reset");
        step(1'b1, 8'h00, 10'h000, 1'b1, "R3 reset-add", 4'h0, 6'h00, 1'b0, "R8 reset");
        // R2: bits of b below the output LSB discarded; -1/256 floors to -1/16
        step(1'b0, 8'h00, 10'h00F, 1'b1, "R2 drop-pos",  4'h3, 6'h05, 1'b0, "R5 pol0 add");
        step(1'b0, 8'h00, 10'h3FF, 1'b1, "R2 floor-neg", 4'h3, 6'h05, 1'b1, "R5 pol0 sub");
        step(1'b0, 8'h10, 10'h100, 1'b0, "R4 equal-sub", 4'h8, 6'h20, 1'b1, "R6 wrap-sub");
        step(1'b0, 8'h7F, 10'h1FF, 1'b1, "R6 wrap-add", 4'h7, 6'h1F, 1'b0, "R6 wrap-add");
        // mid-run reset on the registered variant
        step(1'b1, 8'h80, 10'h1FF, 1'b0, "R6 wrap-sub", 4'h5, 6'h11, 1'b0, "R8 mid reset");
        step(1'b0, 8'h01, 10'h00F, 1'b0, "R2 no-borrow", 4'h1, 6'h01, 1'b0, "R9 zero-fill");
        step(1'b0, 8'h05, 10'h050, 1'b1, "R7 same-cycle", 4'hF, 6'h3F, 1'b1, "R1 neg-int");
        step(1'b0, 8'hC3, 10'h2A7, 1'b0, "R4 mixed-sub", 4'h9, 6'h2B, 1'b1, "R4 sub");
        for (int k = 0; k < 300; k++) begin
            logic [IA_W-1:0] ra;
            logic [IB_W-1:0] rb;
            logic [RA_W-1:0] rra;
            logic [RB_W-1:0] rrb;
            logic            o1;
            logic            o2;
            seed = lcg(seed); ra  = seed[IA_W+7:8];  o1 = seed[31];
            seed = lcg(seed); rb  = seed[IB_W+5:6];  o2 = seed[30];
            seed = lcg(seed); rra = seed[RA_W+9:10];
            seed = lcg(seed); rrb = seed[RB_W+11:12];
            step(1'b0, ra, rb, o1, o1 ? "R3 rand" : "R4 rand",
                 rra, rrb, o2, o2 ? "R1 rand-sub" : "R3 rand-add");
        end
        // flush the last registered expectation
        step(1'b0, 8'h00, 10'h000, 1'b1, "R3 flush", 4'h0, 6'h00, 1'b0, "R8 flush");
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL R7 watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

endmodule